// File: doc/BRIEF.md
# Two-Way Integer/Floating-Point Issue Pairing Stage

This block sits between the fetch buffer and the execution units of a two-way superscalar front end. Every cycle it looks at one 64-bit fetch word. The upper half goes to the integer issue slot and the lower half goes to the floating-point issue slot. The block then decides whether to issue none, one or both of the two instructions. Issue is in order. The floating-point slot can only follow an integer-slot issue from the same word. A held remainder of a word must drain before the fetch buffer moves on.

The block tracks the one-cycle load delay itself. A load issued through the integer slot blocks a use of its result by the other half of the same word. It also blocks a use by either instruction issued in the cycle that follows. Writes still in flight in the execution pipes arrive as two pending-write bit vectors, one for the integer register file and one for the FP register file. When the block cannot consume the whole word, it raises a hold towards the fetch buffer.

Top module: `dip_issue`

## Requirements
- R1: After reset, no issue takes place while `fetch_valid` is low, and `fetch_hold` stays low. A first valid word with no hazards issues both halves in the same cycle with the hold low.
- R2: If the integer-slot instruction reads a register that is blocked, nothing issues and `fetch_hold` is high.
- R3: The FP slot issues on its own only for the remainder of a word whose integer half has already issued. An FP-only issue is always preceded by a cycle with `fetch_hold` high.
- R4: A load in the upper half must not feed the lower half of the same word. The upper half issues and the lower half is kept back with `fetch_hold` high.
- R5: A load that issues in cycle t blocks, in cycle t+1, any instruction in either slot that reads its destination. The block lifts in cycle t+2.
- R6: An FP load in the upper half and an FP operation in the lower half issue together when the operation does not read the load's destination.
- R7: If only the lower half is blocked, the upper half issues. The FP operation then issues alone in a later cycle, once its hazards clear. `fetch_hold` stays high until that happens.
- R8: If the lower half is neither an FP operation nor a no-op, the upper half issues alone. On the next cycle the lower half issues through the integer slot, and `iss_int_word` carries the lower half. A load issued this way starts its own delay shadow.
- R9: A pending bit blocks only sources read from its own register file. Integer pending index k has no effect on an FP source k.
- R10: Instruction fields are as follows. Bits 31:28 hold the class: 0 no-op, 1 integer ALU (int dst, int srcs A and B), 2 integer load (int dst, int src A), 3 FP load (FP dst, int src A), 4 FP store (int src A, FP src B), 5 FP operation (FP dst, FP srcs A and B). Bits 27:23 hold the destination, 22:18 source A and 17:13 source B. The upper half of the fetch word is bits 63:32. An issued integer-slot word equals the upper half, except in the case of R8, and `iss_fp_word` equals the lower half.
- R11: A no-op in the lower half counts as pairable with no sources, and it issues with the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch word present |
| fetch_word | input | 64 | Upper half integer slot, lower half FP slot |
| int_pend | input | 32 | Integer registers with a write in flight |
| fp_pend | input | 32 | FP registers with a write in flight |
| iss_int_vld | output | 1 | Integer slot issues this cycle |
| iss_int_word | output | 32 | Instruction sent to the integer slot |
| iss_fp_vld | output | 1 | FP slot issues this cycle |
| iss_fp_word | output | 32 | Instruction sent to the FP slot |
| fetch_hold | output | 1 | Keep the current fetch word next cycle |

## Verification
The assertions assume three things about the inputs. The fetch buffer keeps the same word and `fetch_valid` high for as long as `fetch_hold` is high. The upper half never carries an FP operation (class 5). A pending bit does not stay set forever. The stimulus follows all three rules. Each word is presented until the hold drops, left-half classes are swept only over 0 to 4, and pending bits are raised only in the first cycle a word is shown. Register indices are drawn from a tiny set, so load shadows and same-word dependencies arise on their own across consecutive words.

// File: rtl/dip_pkg.sv
package dip_pkg;

    localparam int REG_W   = 5;
    localparam int CLS_HI  = 31;
    localparam int CLS_LO  = 28;
    localparam int DST_LO  = 23;
    localparam int SRCA_LO = 18;
    localparam int SRCB_LO = 13;

    typedef enum logic [3:0] {
        CL_NOP  = 4'd0,
        CL_IALU = 4'd1,
        CL_ILD  = 4'd2,
        CL_FLD  = 4'd3,
        CL_FST  = 4'd4,
        CL_FOP  = 4'd5
    } cls_e;

    typedef struct packed {
        logic             is_fp;
        logic [REG_W-1:0] idx;
    } rref_t;

    typedef struct packed {
        logic  v;
        rref_t r;
    } opnd_t;

    typedef struct packed {
        opnd_t sa;
        opnd_t sb;
        rref_t dst;
        logic  is_load;
        logic  pairable;
    } dec_t;

    typedef enum logic [1:0] {
        ST_PAIR = 2'd0,
        ST_RFP  = 2'd1,
        ST_RINT = 2'd2
    } seq_e;

    // Used only by the checks: does word w read register (fp, idx)?
    function automatic logic src_hit(input logic [31:0] w, input logic fp,
                                     input logic [REG_W-1:0] idx);
        logic [REG_W-1:0] a;
        logic [REG_W-1:0] b;
        a = w[SRCA_LO +: REG_W];
        b = w[SRCB_LO +: REG_W];
        unique case (w[CLS_HI:CLS_LO])
            4'd1:    return !fp && (a == idx || b == idx);
            4'd2,
            4'd3:    return !fp && a == idx;
            4'd4:    return (!fp && a == idx) || (fp && b == idx);
            4'd5:    return fp && (a == idx || b == idx);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dip_decode.sv
module dip_decode
    import dip_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic [IW-1:0] word,
    output dec_t          dec
);
    cls_e             cls;
    logic [REG_W-1:0] f_dst;
    logic [REG_W-1:0] f_a;
    logic [REG_W-1:0] f_b;

    always_comb begin
        cls   = cls_e'(word[CLS_HI:CLS_LO]);
        f_dst = word[DST_LO  +: REG_W];
        f_a   = word[SRCA_LO +: REG_W];
        f_b   = word[SRCB_LO +: REG_W];

        dec          = '0;
        dec.sa.r.idx = f_a;
        dec.sb.r.idx = f_b;
        dec.dst.idx  = f_dst;

        case (cls)
            CL_IALU: begin
                dec.sa.v = 1'b1;
                dec.sb.v = 1'b1;
            end
            CL_ILD: begin
                dec.sa.v    = 1'b1;
                dec.is_load = 1'b1;
            end
            CL_FLD: begin
                dec.sa.v      = 1'b1;
                dec.is_load   = 1'b1;
                dec.dst.is_fp = 1'b1;
            end
            CL_FST: begin
                dec.sa.v       = 1'b1;
                dec.sb.v       = 1'b1;
                dec.sb.r.is_fp = 1'b1;
            end
            CL_FOP: begin
                dec.sa.v       = 1'b1;
                dec.sb.v       = 1'b1;
                dec.sa.r.is_fp = 1'b1;
                dec.sb.r.is_fp = 1'b1;
                dec.dst.is_fp  = 1'b1;
                dec.pairable   = 1'b1;
            end
            CL_NOP: begin
                dec.pairable = 1'b1;
            end
            default: begin
                dec.pairable = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dip_hazard.sv
module dip_hazard
    import dip_pkg::*;
#(
    parameter int NREG = 32
) (
    input  opnd_t            sa,
    input  opnd_t            sb,
    input  logic [NREG-1:0]  int_pend,
    input  logic [NREG-1:0]  fp_pend,
    input  logic             sh_v,
    input  rref_t            sh,
    input  logic             pr_v,
    input  rref_t            pr,
    output logic             blocked
);
    logic [1:0] blk;
    opnd_t      src [2];

    assign src[0] = sa;
    assign src[1] = sb;

    for (genvar k = 0; k < 2; k++) begin : g_src
        always_comb begin
            blk[k] = 1'b0;
            if (src[k].v) begin
                if (src[k].r.is_fp) blk[k] = fp_pend[src[k].r.idx];
                else                blk[k] = int_pend[src[k].r.idx];
                if (sh_v && sh == src[k].r) blk[k] = 1'b1;
                if (pr_v && pr == src[k].r) blk[k] = 1'b1;
            end
        end
    end

    assign blocked = |blk;
endmodule

// File: rtl/dip_seq.sv
module dip_seq
    import dip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fetch_valid,
    input  logic  l_blk,
    input  logic  l_is_load,
    input  rref_t l_dst,
    input  logic  r_blk,
    input  logic  r_pairable,
    output seq_e  st,
    output logic  sh_v,
    output rref_t sh,
    output logic  iss_int,
    output logic  iss_fp,
    output logic  hold
);
    typedef struct packed {
        seq_e  st;
        logic  sh_v;
        rref_t sh;
    } seq_st_t;

    seq_st_t cur_q;
    seq_st_t nxt_d;
    logic    consume;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sh_v = 1'b0;
        iss_int    = 1'b0;
        iss_fp     = 1'b0;
        consume    = 1'b0;
        if (fetch_valid) begin
            case (cur_q.st)
                ST_PAIR: begin
                    if (!l_blk) begin
                        iss_int = 1'b1;
                        if (!r_pairable) begin
                            nxt_d.st = ST_RINT;
                        end else if (!r_blk) begin
                            iss_fp  = 1'b1;
                            consume = 1'b1;
                        end else begin
                            nxt_d.st = ST_RFP;
                        end
                    end
                end
                ST_RFP: begin
                    if (!r_blk) begin
                        iss_fp   = 1'b1;
                        consume  = 1'b1;
                        nxt_d.st = ST_PAIR;
                    end
                end
                ST_RINT: begin
                    if (!l_blk) begin
                        iss_int  = 1'b1;
                        consume  = 1'b1;
                        nxt_d.st = ST_PAIR;
                    end
                end
                default: nxt_d.st = ST_PAIR;
            endcase
        end
        if (iss_int && l_is_load) begin
            nxt_d.sh_v = 1'b1;
            nxt_d.sh   = l_dst;
        end
        hold = fetch_valid && !consume;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= ST_PAIR;
            cur_q.sh_v <= 1'b0;
            cur_q.sh   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign st   = cur_q.st;
    assign sh_v = cur_q.sh_v;
    assign sh   = cur_q.sh;
endmodule

// File: rtl/dip_issue.sv
module dip_issue
    import dip_pkg::*;
#(
    parameter int IW   = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [2*IW-1:0] fetch_word,
    input  logic [NREG-1:0] int_pend,
    input  logic [NREG-1:0] fp_pend,
    output logic            iss_int_vld,
    output logic [IW-1:0]   iss_int_word,
    output logic            iss_fp_vld,
    output logic [IW-1:0]   iss_fp_word,
    output logic            fetch_hold
);
    localparam int NSLOT = 2;

    logic [IW-1:0] hi_w;
    logic [IW-1:0] lo_w;
    logic [IW-1:0] cand [NSLOT];
    dec_t          dec  [NSLOT];
    logic          blk  [NSLOT];
    logic          pr_v [NSLOT];
    seq_e          st;
    logic          sh_v;
    rref_t         sh;

    assign hi_w    = fetch_word[2*IW-1:IW];
    assign lo_w    = fetch_word[IW-1:0];
    assign cand[0] = (st == ST_RINT) ? lo_w : hi_w;
    assign cand[1] = lo_w;
    assign pr_v[0] = 1'b0;
    assign pr_v[1] = (st == ST_PAIR) && dec[0].is_load;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        dip_decode #(.IW(IW)) u_dec (
            .word (cand[s]),
            .dec  (dec[s])
        );
        dip_hazard #(.NREG(NREG)) u_hz (
            .sa       (dec[s].sa),
            .sb       (dec[s].sb),
            .int_pend (int_pend),
            .fp_pend  (fp_pend),
            .sh_v     (sh_v),
            .sh       (sh),
            .pr_v     (pr_v[s]),
            .pr       (dec[0].dst),
            .blocked  (blk[s])
        );
    end

    dip_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .l_blk       (blk[0]),
        .l_is_load   (dec[0].is_load),
        .l_dst       (dec[0].dst),
        .r_blk       (blk[1]),
        .r_pairable  (dec[1].pairable),
        .st          (st),
        .sh_v        (sh_v),
        .sh          (sh),
        .iss_int     (iss_int_vld),
        .iss_fp      (iss_fp_vld),
        .hold        (fetch_hold)
    );

    assign iss_int_word = cand[0];
    assign iss_fp_word  = lo_w;

    // ---------------- checks ----------------
    logic arm_q;
    always_ff @(posedge clk) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= 1'b1;
    end

    function automatic logic word_is_load(input logic [IW-1:0] w);
        return w[CLS_HI:CLS_LO] == 4'd2 || w[CLS_HI:CLS_LO] == 4'd3;
    endfunction

    a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !iss_int_vld && !iss_fp_vld |-> fetch_hold);

    a_r3_fp_alone_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q && iss_fp_vld && !iss_int_vld |-> $past(fetch_hold));

    a_r4_no_same_word_use: assert property (@(posedge clk) disable iff (!rst_n)
        iss_int_vld && iss_fp_vld && word_is_load(iss_int_word)
        |-> !src_hit(iss_fp_word, iss_int_word[CLS_LO] == 1'b1,
                     iss_int_word[DST_LO +: REG_W]));

    a_r5_shadow_int_slot: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q && iss_int_vld && $past(iss_int_vld && word_is_load(iss_int_word))
        |-> !src_hit(iss_int_word, $past(iss_int_word[CLS_LO]),
                     $past(iss_int_word[DST_LO +: REG_W])));

    a_r5_shadow_fp_slot: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q && iss_fp_vld && $past(iss_int_vld && word_is_load(iss_int_word))
        |-> !src_hit(iss_fp_word, $past(iss_int_word[CLS_LO]),
                     $past(iss_int_word[DST_LO +: REG_W])));

    a_r8_single_no_fp_next: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && iss_int_vld && !iss_fp_vld && fetch_hold
        && lo_w[CLS_HI:CLS_LO] != 4'd0 && lo_w[CLS_HI:CLS_LO] != 4'd5
        |=> !iss_fp_vld);

endmodule

// File: tb/dip_issue_bench.sv
module dip_issue_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fvld = 1'b0;
    logic [63:0] fword = '0;
    logic [31:0] ipend = '0;
    logic [31:0] fpend = '0;
    logic        iss_int_vld, iss_fp_vld, fetch_hold;
    logic [31:0] iss_int_word, iss_fp_word;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dip_issue u_dip_issue (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fvld), .fetch_word(fword),
        .int_pend(ipend), .fp_pend(fpend),
        .iss_int_vld(iss_int_vld), .iss_int_word(iss_int_word),
        .iss_fp_vld(iss_fp_vld), .iss_fp_word(iss_fp_word),
        .fetch_hold(fetch_hold)
    );

    function automatic logic [31:0] mk(input int c, input int d, input int a, input int b);
        return {c[3:0], d[4:0], a[4:0], b[4:0], 13'b0};
    endfunction

    function automatic logic uses(input logic [31:0] w, input logic fp, input logic [4:0] r);
        case (w[31:28])
            4'd1: return !fp && (w[22:18] == r || w[17:13] == r);
            4'd2, 4'd3: return !fp && w[22:18] == r;
            4'd4: return (!fp && w[22:18] == r) || (fp && w[17:13] == r);
            4'd5: return fp && (w[22:18] == r || w[17:13] == r);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic isld(input logic [31:0] w);
        return w[31:28] == 4'd2 || w[31:28] == 4'd3;
    endfunction

    function automatic logic blkd(input logic [31:0] w, input logic [31:0] ip,
        input logic [31:0] fp, input logic sv, input logic sfp, input logic [4:0] si,
        input logic pv, input logic pfp, input logic [4:0] pi);
        for (int i = 0; i < 32; i++)
            if ((ip[i] && uses(w, 1'b0, i[4:0])) || (fp[i] && uses(w, 1'b1, i[4:0])))
                return 1'b1;
        return (sv && uses(w, sfp, si)) || (pv && uses(w, pfp, pi));
    endfunction

    task automatic drv(input logic [63:0] w, input logic v, input logic [31:0] ip,
                       input logic [31:0] fp);
        @(negedge clk);
        fword = w; fvld = v; ipend = ip; fpend = fp;
        #1;
    endtask

    task automatic ck(input string tag, input logic ei, input logic ef, input logic eh);
        total++;
        if ({iss_int_vld, iss_fp_vld, fetch_hold} !== {ei, ef, eh}) begin
            bad++;
            $display("FAIL %s: int/fp/hold=%b%b%b expected %b%b%b", tag,
                     iss_int_vld, iss_fp_vld, fetch_hold, ei, ef, eh);
        end
    endtask

    task automatic ckw(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: word=%h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        drv('0, 1'b0, '0, '0);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] w;
        int m_st;
        logic m_sv, m_sfp;
        logic [4:0] m_si;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: idle after reset, then a clean pair
        idle();                                     ck("R1", 0, 0, 0);
        w = {mk(1, 3, 1, 2), mk(5, 4, 5, 6)};
        drv(w, 1, '0, '0);                          ck("R1", 1, 1, 0);
        ckw("R10 int word", iss_int_word, w[63:32]);
        ckw("R10 fp word", iss_fp_word, w[31:0]);

        // R2 / R9: int pending blocks left; fp pending same index does not
        w = {mk(1, 3, 1, 2), mk(5, 4, 7, 8)};
        drv(w, 1, 32'h2, '0);                       ck("R2", 0, 0, 1);
        drv(w, 1, '0, 32'h2);                       ck("R9", 1, 1, 0);
        idle();

        // R4: FP load feeding same-word FP op
        w = {mk(3, 9, 1, 0), mk(5, 10, 9, 2)};
        drv(w, 1, '0, '0);                          ck("R4", 1, 0, 1);
        drv(w, 1, '0, '0);                          ck("R5", 0, 0, 1);
        drv(w, 1, '0, '0);                          ck("R3", 0, 1, 0);
        ckw("R3 fp word", iss_fp_word, w[31:0]);
        idle();

        // R6: independent FP load + FP op
        drv({mk(3, 9, 1, 0), mk(5, 10, 11, 12)}, 1, '0, '0); ck("R6", 1, 1, 0);
        idle();

        // R5 / R11: int load shadow on next word's left slot
        drv({mk(2, 5, 1, 0), 32'h0}, 1, '0, '0);     ck("R11", 1, 1, 0);
        w = {mk(1, 6, 5, 2), 32'h0};
        drv(w, 1, '0, '0);                          ck("R5", 0, 0, 1);
        drv(w, 1, '0, '0);                          ck("R5", 1, 1, 0);
        idle();

        // R5: FP load shadow on next word's right slot
        drv({mk(3, 13, 1, 0), 32'h0}, 1, '0, '0);    ck("R5", 1, 1, 0);
        w = {mk(1, 1, 2, 3), mk(5, 4, 13, 13)};
        drv(w, 1, '0, '0);                          ck("R5", 1, 0, 1);
        drv(w, 1, '0, '0);                          ck("R5", 0, 1, 0);
        idle();

        // R7: right alone blocked by FP pending
        w = {mk(1, 1, 2, 3), mk(5, 4, 14, 15)};
        drv(w, 1, '0, 32'h4000);                    ck("R7", 1, 0, 1);
        drv(w, 1, '0, 32'h4000);                    ck("R7", 0, 0, 1);
        drv(w, 1, '0, '0);                          ck("R7", 0, 1, 0);
        idle();

        // R8: non-FP lower half goes through the integer slot
        w = {mk(1, 1, 2, 3), mk(2, 7, 2, 0)};
        drv(w, 1, '0, '0);                          ck("R8", 1, 0, 1);
        ckw("R8 first word", iss_int_word, w[63:32]);
        drv(w, 1, '0, '0);                          ck("R8", 1, 0, 0);
        ckw("R8 second word", iss_int_word, w[31:0]);
        w = {mk(1, 8, 7, 3), 32'h0};
        drv(w, 1, '0, '0);                          ck("R8", 0, 0, 1);
        drv(w, 1, '0, '0);                          ck("R8", 1, 1, 0);
        idle();

        // Sweep: left classes 0..4, right classes 0..5, register variants
        m_st = 0; m_sv = 0; m_sfp = 0; m_si = '0;
        for (int lc = 0; lc < 5; lc++) begin
            for (int rc = 0; rc < 6; rc++) begin
                for (int v = 0; v < 8; v++) begin
                    logic [31:0] lw, rw, lcand, ip, fp;
                    logic lb, rb, pv, ei, ef, cons, done;
                    int nst;
                    lw = mk(lc, 1 + v % 2, 1 + (v / 2) % 2, 2);
                    rw = mk(rc, 1 + (v / 2) % 2, 1 + v % 2, 1 + (v / 4) % 2);
                    done = 0;
                    for (int c = 0; c < 6 && !done; c++) begin
                        ip = (c == 0 && v >= 4) ? 32'h6 : 32'h0;
                        fp = (c == 0 && v == 3) ? 32'h4 : 32'h0;
                        drv({lw, rw}, 1, ip, fp);
                        lcand = (m_st == 2) ? rw : lw;
                        lb = blkd(lcand, ip, fp, m_sv, m_sfp, m_si, 0, 0, '0);
                        pv = (m_st == 0) && isld(lw);
                        rb = blkd(rw, ip, fp, m_sv, m_sfp, m_si, pv,
                                  lw[31:28] == 4'd3, lw[27:23]);
                        ei = 0; ef = 0; cons = 0; nst = m_st;
                        case (m_st)
                            0: if (!lb) begin
                                   ei = 1;
                                   if (rw[31:28] == 4'd0 || rw[31:28] == 4'd5) begin
                                       if (!rb) begin ef = 1; cons = 1; end
                                       else nst = 1;
                                   end else nst = 2;
                               end
                            1: if (!rb) begin ef = 1; cons = 1; nst = 0; end
                            default: if (!lb) begin ei = 1; cons = 1; nst = 0; end
                        endcase
                        ck("R3/R10 sweep", ei, ef, !cons);
                        if (ei) ckw("R10 sweep int word", iss_int_word, lcand);
                        m_sv = ei && isld(lcand);
                        m_sfp = lcand[31:28] == 4'd3;
                        m_si = lcand[27:23];
                        m_st = nst;
                        done = cons;
                    end
                    if (!done) begin
                        total++; bad++;
                        $display("FAIL R7 sweep: word never consumed, expected consumed");
                    end
                end
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule